// File: doc/BRIEF.md
# Pipelined Burst Static RAM Core

This block is a synchronous static RAM with a four-beat burst engine in front of an on-chip array. Every control and address input is registered on the rising clock edge. A cycle starts from one of two active-low address strobes: a processor-side strobe that only takes effect while the master enable is active, and a controller-side strobe that is always honoured and can also end a burst by deselecting. The two low address bits then step through a four-word burst on each advance edge, in either interleaved (XOR) or linear (wrap within four) order.

Writes come from the controller-side strobe only, either to every byte lane or to selected lanes. Read data reaches the output after one register (flow-through) or after two registers (pipelined), chosen by a static select input. The output drive is gated by an asynchronous active-low output enable and by a sleep input. The array depth is set by `ADDR_W`. The default is 1024 words for elaboration. `ADDR_W = 17` gives the full 128K-word array. The output is a plain data bus plus a drive-enable flag, so that a tristate pad outside the block can use it.

Top module: `pburst_sram`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `dOutEn` is 0.
- R2: An edge with a strobe asserted and all three enables active (`enMasterN`=0, `enHighIn`=1, `enLowN`=0) captures `addrIn` as the burst start address and makes an access to that address.
- R3: On an edge where `enMasterN`=1, `cpuStartN`=0 is ignored: with `advN`=0 a running burst advances, and otherwise nothing happens. `ctlStartN`=0 on an edge with any enable inactive deselects the block and ends the burst.
- R4: A start from `cpuStartN` (also when `ctlStartN` is low on the same edge) is always a read. Write enables are used only on an edge where `ctlStartN`=0 and `cpuStartN` is not taking effect.
- R5: With `interleaveSel`=1, beat k of a burst accesses address bits [1:0] = start[1:0] XOR k. The upper bits are unchanged.
- R6: With `interleaveSel`=0, beat k accesses address bits [1:0] = (start[1:0] + k) mod 4. The upper bits are unchanged.
- R7: An edge with no strobe and `advN`=0 during an active burst moves to the next beat and accesses it. With `advN`=1 there is no access, and the flow-through output is not driven in the following cycle.
- R8: `allWrN`=0 writes all four lanes. Otherwise `byteWrN`=0 writes each lane i whose `laneWrN[i]` is 0. Lane i is `dIn[9i+8:9i]`. The mask chosen at the start edge applies to every beat of a write burst, and `dIn` is taken on each write beat's edge.
- R9: With `flowThru`=1, read data of an access is on `dOut` in the cycle right after its edge. With `flowThru`=0, it is there one cycle later.
- R10: After a deselect edge, `dOutEn` is 0 in the next cycle in both output modes, including a pipelined read still in flight.
- R11: `outEnN`=1 forces `dOutEn` to 0 at once, without a clock edge, and `dOut` reads 0 whenever `dOutEn` is 0.
- R12: An edge with `sleepIn`=1 changes no state and performs no write or read. `dOutEn` is 0 while `sleepIn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | Burst start address |
| cpuStartN | input | 1 | Processor-side start strobe, active low, gated by the master enable |
| ctlStartN | input | 1 | Controller-side start strobe, active low |
| advN | input | 1 | Burst advance, active low |
| enMasterN | input | 1 | Master chip enable, active low |
| enHighIn | input | 1 | Chip enable, active high |
| enLowN | input | 1 | Chip enable, active low |
| allWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Per-lane write qualifier, active low |
| laneWrN | input | 4 | Per-lane write enables, active low |
| interleaveSel | input | 1 | 1 selects interleaved burst order, 0 selects linear |
| flowThru | input | 1 | 1 selects the flow-through output, 0 selects pipelined |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepIn | input | 1 | Power-down: no cycles accepted |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data, 0 when not driven |
| dOutEn | output | 1 | Output drive enable |

## Verification
Each access is due at the negative edge after its clock edge in flow-through mode, and one full cycle later in pipelined mode. The bench steps one edge at a time and compares `dOut` against a reference memory only at those points. In pipelined bursts it therefore checks beat k-1 after edge k and drains the last beat with an extra idle edge. Deselect, hold, blocked-strobe and sleep cases are checked at the first cycle in which an output would otherwise show up. Only the output-enable check is made with a short delay and no clock edge, because that path has no register.

// File: rtl/pburst_sram_pkg.sv
package pburst_sram_pkg;

  localparam int LANES = 4;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic             flush;
    logic [LANES-1:0] laneMask;
  } strobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    return interleave ? (base ^ beat) : 2'(base + beat);
  endfunction

endpackage

// File: rtl/pburst_sram_ctrl.sv
module pburst_sram_ctrl
  import pburst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cpuStartN,
  input  logic              ctlStartN,
  input  logic              advN,
  input  logic              enMasterN,
  input  logic              enHighIn,
  input  logic              enLowN,
  input  logic              allWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              interleaveSel,
  input  logic              sleepIn,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] accAddr
);

  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        beatCnt;
  logic              active;
  logic              isWrite;
  logic [LANES-1:0]  maskReg;

  logic selOk, cpuGo, ctlGo, anyStart, newSel, deselect, advance, wrNow;
  logic [LANES-1:0] maskNow;
  logic [1:0]       nextBeat;

  always_comb begin
    selOk    = !enMasterN && enHighIn && !enLowN;
    cpuGo    = !cpuStartN && !enMasterN;
    ctlGo    = !ctlStartN && !cpuGo;
    anyStart = cpuGo || !ctlStartN;
    newSel   = anyStart && selOk;
    deselect = anyStart && !selOk;
    advance  = !anyStart && !advN && active;
    wrNow    = ctlGo && (!allWrN || (!byteWrN && (laneWrN != '1)));
    maskNow  = !allWrN ? '1 : ~laneWrN;
    nextBeat = 2'(beatCnt + 2'd1);
  end

  always_comb begin
    strobe = '0;
    if (newSel) accAddr = addrIn;
    else accAddr = {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], nextBeat, interleaveSel)};
    if (!sleepIn) begin
      strobe.wrEn     = newSel ? wrNow : (advance && isWrite);
      strobe.rdEn     = newSel ? !wrNow : (advance && !isWrite);
      strobe.flush    = deselect;
      strobe.laneMask = newSel ? maskNow : maskReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      active   <= 1'b0;
      isWrite  <= 1'b0;
      maskReg  <= '0;
    end else if (!sleepIn) begin
      if (newSel) begin
        baseAddr <= addrIn;
        beatCnt  <= '0;
        active   <= 1'b1;
        isWrite  <= wrNow;
        maskReg  <= maskNow;
      end else if (deselect) begin
        active <= 1'b0;
      end else if (advance) begin
        beatCnt <= nextBeat;
      end
    end
  end

endmodule

// File: rtl/pburst_sram_dp.sv
module pburst_sram_dp
  import pburst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              flowThru,
  input  logic              outEnN,
  input  logic              sleepIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] stage1Data, stage2Data, selData;
  logic              stage1Valid, stage2Valid, selValid;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.laneMask[l]) memArr[accAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.rdEn) stage1Data <= memArr[accAddr];
    stage2Data <= stage1Data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else if (strobe.flush) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= strobe.rdEn;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    selData  = flowThru ? stage1Data : stage2Data;
    selValid = flowThru ? stage1Valid : stage2Valid;
    dOutEn   = selValid && !outEnN && !sleepIn;
    dOut     = dOutEn ? selData : '0;
  end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import pburst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cpuStartN,
  input  logic              ctlStartN,
  input  logic              advN,
  input  logic              enMasterN,
  input  logic              enHighIn,
  input  logic              enLowN,
  input  logic              allWrN,
  input  logic              byteWrN,
  input  logic [3:0]        laneWrN,
  input  logic              interleaveSel,
  input  logic              flowThru,
  input  logic              outEnN,
  input  logic              sleepIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] accAddr;

  pburst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
    .cpuStartN(cpuStartN), .ctlStartN(ctlStartN), .advN(advN),
    .enMasterN(enMasterN), .enHighIn(enHighIn), .enLowN(enLowN),
    .allWrN(allWrN), .byteWrN(byteWrN), .laneWrN(laneWrN),
    .interleaveSel(interleaveSel), .sleepIn(sleepIn),
    .strobe(strobe), .accAddr(accAddr)
  );

  pburst_sram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .accAddr(accAddr),
    .dIn(dIn), .flowThru(flowThru), .outEnN(outEnN), .sleepIn(sleepIn),
    .dOut(dOut), .dOutEn(dOutEn)
  );

endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cpuStartN,
  input logic ctlStartN,
  input logic advN,
  input logic enMasterN,
  input logic enHighIn,
  input logic enLowN,
  input logic allWrN,
  input logic flowThru,
  input logic sleepIn,
  input logic dOutEn
);

  // R3 / R10: controller strobe with master enable off deselects
  p_ctl_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctlStartN && enMasterN && !sleepIn) |=> !dOutEn);

  // R3: processor strobe blocked by master enable, no advance, gives no access
  p_cpu_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpuStartN && enMasterN && ctlStartN && advN && !sleepIn) |=> !(flowThru && dOutEn));

  // R4: a controller-started write produces no read data
  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctlStartN && cpuStartN && !enMasterN && enHighIn && !enLowN && !allWrN && !sleepIn)
    |=> !(flowThru && dOutEn));

  // R7: hold edge performs no access
  p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlStartN && cpuStartN && advN && !sleepIn) |=> !(flowThru && dOutEn));

  // R12: an edge taken while asleep performs no read
  p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleepIn |=> !(flowThru && dOutEn));

endmodule

bind pburst_sram pburst_sram_chk u_chk (.*);

// File: tb/pburst_sram_tb.sv
module pburst_sram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 36;

  localparam logic [7:0]  T_ADDR [8] = '{8'h05, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'hFF, 8'h00};
  localparam logic [35:0] T_DATA [8] = '{36'h1_2345_6789, 36'hF_FFFF_FFFF, 36'hA_AAAA_AAAA,
                                         36'h5_5555_5555, 36'h0_0000_0000, 36'h9_8765_4321,
                                         36'h3_C3C3_C3C3, 36'h7_1111_2222};
  localparam logic        T_GW   [8] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [3:0]  T_LANE [8] = '{4'hF, 4'b1110, 4'b0111, 4'b1001, 4'b0000, 4'b1111,
                                         4'b0000, 4'b1011};

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addrIn;
  logic cpuStartN, ctlStartN, advN, enMasterN, enHighIn, enLowN;
  logic allWrN, byteWrN;
  logic [3:0] laneWrN;
  logic interleaveSel, flowThru, outEnN, sleepIn;
  logic [DW-1:0] dIn, dOut;
  logic dOutEn;

  logic [DW-1:0] refMem [256];
  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  pburst_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .cpuStartN(cpuStartN),
    .ctlStartN(ctlStartN), .advN(advN), .enMasterN(enMasterN),
    .enHighIn(enHighIn), .enLowN(enLowN), .allWrN(allWrN), .byteWrN(byteWrN),
    .laneWrN(laneWrN), .interleaveSel(interleaveSel), .flowThru(flowThru),
    .outEnN(outEnN), .sleepIn(sleepIn), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpuStartN = 1; ctlStartN = 1; advN = 1; allWrN = 1; byteWrN = 1;
    laneWrN = 4'hF; enMasterN = 0; enHighIn = 1; enLowN = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] beatAddr(input logic [7:0] s, input int k, input logic inter);
    logic [1:0] kk = 2'(k);
    return {s[7:2], inter ? (s[1:0] ^ kk) : 2'(s[1:0] + kk)};
  endfunction

  task automatic refWrite(input logic [7:0] a, input logic [35:0] d, input logic [3:0] mask);
    for (int l = 0; l < 4; l++) if (mask[l]) refMem[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic writeWord(input logic [7:0] a, input logic [35:0] d, input logic gw,
                           input logic [3:0] lanesN);
    idle();
    ctlStartN = 0; addrIn = a; dIn = d;
    if (gw) allWrN = 0;
    else begin byteWrN = 0; laneWrN = lanesN; end
    tick();
    idle();
    refWrite(a, d, gw ? 4'hF : ~lanesN);
  endtask

  task automatic readBurst(input string tag, input logic [7:0] s, input int n,
                           input logic inter, input logic ft);
    interleaveSel = inter; flowThru = ft;
    for (int k = 0; k < n; k++) begin
      idle();
      if (k == 0) begin ctlStartN = 0; addrIn = s; end
      else advN = 0;
      tick();
      if (ft) begin
        chk({tag, " R9 en"}, 36'(dOutEn), 36'd1);
        chk(tag, dOut, refMem[beatAddr(s, k, inter)]);
      end else if (k == 0) chk({tag, " R9 latency"}, 36'(dOutEn), 36'd0);
      else chk(tag, dOut, refMem[beatAddr(s, k-1, inter)]);
    end
    idle();
    tick();
    if (ft) chk({tag, " R7 idle"}, 36'(dOutEn), 36'd0);
    else chk(tag, dOut, refMem[beatAddr(s, n-1, inter)]);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); addrIn = '0; dIn = '0;
    interleaveSel = 0; flowThru = 1; outEnN = 0; sleepIn = 0;
    repeat (3) tick();
    chk("R1 reset", 36'(dOutEn), 36'd0);
    rst_n = 1;
    tick();
    chk("R1 after reset", 36'(dOutEn), 36'd0);

    // R8 global writes preload the whole array
    for (int a = 0; a < 256; a++)
      writeWord(8'(a), {4'h0, 8'(a), ~8'(a), 8'(a * 3), 8'hC3}, 1'b1, 4'hF);

    // table of global and lane writes, each read back (R2, R8)
    for (int i = 0; i < 8; i++) begin
      writeWord(T_ADDR[i], T_DATA[i], T_GW[i], T_LANE[i]);
      readBurst("R8 lane write readback", T_ADDR[i], 1, 1'b0, 1'b1);
    end

    // bursts from each starting offset in both orders (R5, R6)
    for (int s = 0; s < 4; s++) begin
      readBurst("R5 interleaved", 8'(8'h40 + s), 4, 1'b1, 1'b1);
      readBurst("R6 linear", 8'(8'h40 + s), 4, 1'b0, 1'b1);
    end
    // pipelined bursts (R9)
    readBurst("R9 pipelined linear", 8'h53, 4, 1'b0, 1'b0);
    readBurst("R9 pipelined interleaved", 8'h52, 4, 1'b1, 1'b0);

    // write burst, linear from offset 2, mask from start edge (R8, R6)
    interleaveSel = 0;
    for (int k = 0; k < 4; k++) begin
      idle();
      if (k == 0) begin ctlStartN = 0; addrIn = 8'h82; byteWrN = 0; laneWrN = 4'b1100; end
      else advN = 0;
      dIn = 36'hE_0000_0000 + 36'(k * 36'h1_0101);
      tick();
      refWrite(beatAddr(8'h82, k, 1'b0), dIn, 4'b0011);
    end
    idle(); tick();
    readBurst("R8 burst write", 8'h80, 4, 1'b0, 1'b1);

    // processor strobe start ignores write enables (R4)
    flowThru = 1;
    idle(); cpuStartN = 0; allWrN = 0; addrIn = 8'h10; dIn = 36'h0;
    tick();
    chk("R4 cpu start reads", dOut, refMem[8'h10]);
    idle(); cpuStartN = 0; ctlStartN = 0; allWrN = 0; addrIn = 8'h11; dIn = 36'h0;
    tick();
    chk("R4 both strobes read", dOut, refMem[8'h11]);
    idle(); tick();
    readBurst("R4 no write happened", 8'h10, 2, 1'b0, 1'b1);

    // processor strobe blocked by master enable (R3)
    idle(); ctlStartN = 0; addrIn = 8'h20; tick();
    chk("R3 start", dOut, refMem[8'h20]);
    idle(); cpuStartN = 0; enMasterN = 1; addrIn = 8'h99; advN = 0; tick();
    chk("R3 blocked strobe advances", dOut, refMem[8'h21]);
    idle(); cpuStartN = 0; enMasterN = 1; addrIn = 8'h99; tick();
    chk("R3 blocked strobe no access", 36'(dOutEn), 36'd0);

    // controller strobe deselects with master enable off (R3, R10)
    idle(); ctlStartN = 0; addrIn = 8'h30; tick();
    chk("R10 read before deselect", dOut, refMem[8'h30]);
    idle(); ctlStartN = 0; enMasterN = 1; tick();
    chk("R10 deselect off", 36'(dOutEn), 36'd0);
    idle(); advN = 0; tick();
    chk("R3 burst ended", 36'(dOutEn), 36'd0);

    // pipelined read flushed by deselect (R10)
    flowThru = 0;
    idle(); tick();
    idle(); ctlStartN = 0; addrIn = 8'h31; tick();
    idle(); ctlStartN = 0; enHighIn = 0; tick();
    chk("R10 pipelined flush", 36'(dOutEn), 36'd0);
    idle(); tick();
    chk("R10 stays off", 36'(dOutEn), 36'd0);

    // asynchronous output enable (R11)
    flowThru = 1;
    idle(); ctlStartN = 0; addrIn = 8'h44; tick();
    outEnN = 1; #1;
    chk("R11 oe off en", 36'(dOutEn), 36'd0);
    chk("R11 oe off data", dOut, 36'd0);
    outEnN = 0; #1;
    chk("R11 oe on", dOut, refMem[8'h44]);
    idle(); tick();

    // hold inside a burst (R7)
    idle(); ctlStartN = 0; addrIn = 8'h60; tick();
    idle(); tick();
    chk("R7 hold", 36'(dOutEn), 36'd0);
    idle(); advN = 0; tick();
    chk("R7 advance after hold", dOut, refMem[8'h61]);
    idle(); tick();

    // sleep blocks a write and drives nothing (R12)
    sleepIn = 1;
    idle(); ctlStartN = 0; allWrN = 0; addrIn = 8'h50; dIn = 36'h0; tick();
    chk("R12 asleep", 36'(dOutEn), 36'd0);
    sleepIn = 0;
    idle(); tick();
    readBurst("R12 write blocked", 8'h50, 1, 1'b0, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule